// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives the external memory bus of a small 8-bit controller core. It counts oscillator clocks in machine cycles of twelve, and each machine cycle is split into two halves of six clocks. In an ordinary machine cycle each half starts with a two-clock address latch strobe (`ale`). The low address byte is placed on a shared byte bus around the falling edge of that strobe. The program-store read strobe (`psenN`) then follows if the core asked for a code fetch in that half. The high address byte sits on a separate port for the whole half.

When the core raises a data request before a machine cycle starts, that machine cycle becomes a data cycle. It keeps only the first latch strobe and puts out no program-store strobe at all. In their place it drives one long read strobe (`rdN`) or write strobe (`wrN`). For a write, the data byte follows the low address on the shared bus. The high port carries either the upper half of a 16-bit data address or the contents of the core's port output register, depending on the addressing width of the access. A 4K limit input clears the top four bits of every address-derived high byte.

The block samples all of its request inputs at half and machine-cycle boundaries and then runs the cycle by itself, so the core only has to present stable values on the last clock before a boundary.

Top module: `extbus_sequencer`

## Requirements
- R1: While `rst` is high and on the clock after it, `ale` is low, `psenN`, `rdN` and `wrN` are high and `busLoOe` is low.
- R2: In a fetch machine cycle (phases 0 to 11, phase 0 being the first clock after the cycle boundary), `ale` is high in phases 0, 1, 6 and 7 and low elsewhere, whatever the value of `fetchEn`.
- R3: In a fetch machine cycle, `psenN` is low in positions 3, 4 and 5 of a half (position = phase modulo 6) exactly when `fetchEn` was sampled high for that half, and high otherwise.
- R4: In a fetch half, `busLoOe` is high only in positions 1 and 2, and `busLoOut` then equals bits 7:0 of the fetch address sampled for that half. The bus is released during the program-store strobe and on the clock after it rises.
- R5: A machine cycle is a data cycle when `dataReq` is high on the last clock of the previous machine cycle. In a data cycle, `ale` is high only in phases 0 and 1, and `psenN` stays high throughout.
- R6: In a data cycle, the strobe chosen by `dataWrite` (1 = write, `wrN`; 0 = read, `rdN`) is low in phases 5 to 10, and the other strobe stays high. The next `ale` pulse rises one clock after the strobe returns high.
- R7: In a data cycle, `busLoOut` carries bits 7:0 of the data address in phases 1 and 2. For a write, `busLoOut` carries `wrData` in phases 3 to 11, with `busLoOe` high in phases 1 to 11. For a read, `busLoOe` is high only in phases 1 and 2.
- R8: `busHi` carries bits 15:8 of the fetch address in a fetch half. In a data cycle it carries bits 15:8 of the data address when `dataWide` is 1, and `portReg` when `dataWide` is 0.
- R9: When `limitTo4k` is high, bits 7:4 of `busHi` are zero whenever `busHi` carries an address byte. The `portReg` value on a narrow data access is passed unchanged.
- R10: The fetch address and `fetchEn` are sampled on the last clock of each half. The data request, address, direction, width, write data and `portReg` are sampled on the last clock of the machine cycle. Changes at other times have no effect on the cycle in progress.
- R11: `rdN` and `wrN` are never low together. While either is low, `psenN` is high and `ale` is low. `psenN` is never low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchEn | input | 1 | Code fetch wanted in the next half |
| fetchAddr | input | 16 | Code address for the next half |
| dataReq | input | 1 | Make the next machine cycle a data cycle |
| dataWrite | input | 1 | Data cycle direction, 1 = write |
| dataWide | input | 1 | 1 = 16-bit data address, 0 = 8-bit address with port byte |
| dataAddr | input | 16 | Data address |
| wrData | input | 8 | Byte to write |
| portReg | input | 8 | Port output register value for 8-bit accesses |
| limitTo4k | input | 1 | Clear address bits 15:12 on the high port |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program-store read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| busLoOut | output | 8 | Shared low address / write data byte |
| busLoOe | output | 1 | Output enable of the shared byte bus |
| busHi | output | 8 | High address port |

## Verification
A phase counter that slips shows up at once as a shifted `ale` pulse: within six clocks, the strobe starts a position early or late. A wrongly latched cycle kind appears within the same machine cycle. The bench then sees a program-store strobe where a read or write strobe belongs, or a second `ale` pulse in a data cycle. A stale or misrouted address or data register shows on `busLoOut` or `busHi` in the very half it should serve. The bench therefore compares every output on every clock of each directed cycle, including the clocks right after the inputs have been changed on purpose.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  // phase counter width and machine-cycle geometry (oscillator clocks)
  localparam int PH_W = 4;
  localparam logic [PH_W-1:0] CYC_LEN  = 4'd12;
  localparam logic [PH_W-1:0] HALF_LEN = 4'd6;
  localparam logic [PH_W-1:0] CYC_LAST  = CYC_LEN - 4'd1;
  localparam logic [PH_W-1:0] HALF_LAST = HALF_LEN - 4'd1;

  // latch strobe width; everything else is placed relative to its fall
  localparam logic [PH_W-1:0] ALE_W      = 4'd2;
  localparam logic [PH_W-1:0] ADR_FIRST  = ALE_W - 4'd1;   // one before fall
  localparam logic [PH_W-1:0] ADR_LAST   = ALE_W;          // one after fall
  localparam logic [PH_W-1:0] PSEN_FIRST = ALE_W + 4'd1;
  localparam logic [PH_W-1:0] PSEN_LAST  = HALF_LAST;
  localparam logic [PH_W-1:0] STB_FIRST  = ALE_W + 4'd3;
  localparam logic [PH_W-1:0] STB_LAST   = STB_FIRST + 4'd5; // six clocks
  localparam logic [PH_W-1:0] WDAT_FIRST = ADR_LAST + 4'd1;
  localparam logic [PH_W-1:0] WDAT_LAST  = STB_LAST + 4'd1;

  typedef enum logic {KIND_FETCH = 1'b0, KIND_DATA = 1'b1} cycKind_t;

  // control -> datapath strobe bundle
  typedef struct packed {
    logic ale;
    logic psenN;
    logic rdN;
    logic wrN;
    logic latchHalf;   // sample fetch inputs this clock
    logic latchCycle;  // sample data request inputs this clock
    logic dataCycle;   // current machine cycle is a data cycle
    logic driveAddr;   // low address on the shared bus
    logic driveWdata;  // write byte on the shared bus
  } busStrobes_t;

endpackage

// File: rtl/extbus_timebase.sv
module extbus_timebase
  import extbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            halfEnd,
  output logic            cycleEnd
);

  logic [PH_W-1:0] phaseQ;

  // reset parks on the last clock so the first clock after reset is phase 0
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= CYC_LAST;
    end else if (phaseQ == CYC_LAST) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + 4'd1;
    end
  end

  assign phase    = phaseQ;
  assign cycleEnd = (phaseQ == CYC_LAST);
  assign halfEnd  = (phaseQ == CYC_LAST) || (phaseQ == HALF_LAST);

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase,
  input  logic            halfEnd,
  input  logic            cycleEnd,
  input  logic            fetchEn,
  input  logic            dataReq,
  input  logic            dataWrite,
  output busStrobes_t     strobes
);

  cycKind_t        kindQ;
  logic            writeQ;
  logic            fetchOnQ;
  logic [PH_W-1:0] pos;
  logic            inAdr;
  logic            inStb;
  logic            inWdat;

  always_ff @(posedge clk) begin
    if (rst) begin
      kindQ    <= KIND_FETCH;
      writeQ   <= 1'b0;
      fetchOnQ <= 1'b0;
    end else begin
      if (cycleEnd) begin
        kindQ  <= dataReq ? KIND_DATA : KIND_FETCH;
        writeQ <= dataWrite;
      end
      if (halfEnd) begin
        fetchOnQ <= fetchEn;
      end
    end
  end

  // position inside the current half
  always_comb begin
    if (phase >= HALF_LEN) pos = phase - HALF_LEN;
    else                   pos = phase;
  end

  always_comb begin
    inAdr  = (pos >= ADR_FIRST) && (pos <= ADR_LAST) && (phase < HALF_LEN || kindQ == KIND_FETCH);
    inStb  = (phase >= STB_FIRST) && (phase <= STB_LAST);
    inWdat = (phase >= WDAT_FIRST) && (phase <= WDAT_LAST);
  end

  always_comb begin
    strobes            = '0;
    strobes.latchHalf  = halfEnd;
    strobes.latchCycle = cycleEnd;
    strobes.dataCycle  = (kindQ == KIND_DATA);
    strobes.psenN      = 1'b1;
    strobes.rdN        = 1'b1;
    strobes.wrN        = 1'b1;
    strobes.driveAddr  = inAdr;
    if (kindQ == KIND_FETCH) begin
      strobes.ale   = (pos < ALE_W);
      strobes.psenN = !(fetchOnQ && (pos >= PSEN_FIRST) && (pos <= PSEN_LAST));
    end else begin
      strobes.ale        = (phase < ALE_W);
      strobes.rdN        = !(inStb && !writeQ);
      strobes.wrN        = !(inStb && writeQ);
      strobes.driveWdata = inWdat && writeQ;
    end
  end

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int KEEP_BITS = 12
)(
  input  logic                     clk,
  input  logic                     rst,
  input  busStrobes_t              strobes,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic                     dataWide,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] portReg,
  input  logic                     limitTo4k,
  output logic [DATA_W-1:0]        busLoOut,
  output logic                     busLoOe,
  output logic [ADDR_W-DATA_W-1:0] busHi
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] fAddrQ;
  logic [ADDR_W-1:0] dAddrQ;
  logic [DATA_W-1:0] wDataQ;
  logic [HI_W-1:0]   portQ;
  logic              wideQ;
  logic [HI_W-1:0]   hiAddr;
  logic [HI_W-1:0]   hiLimited;

  always_ff @(posedge clk) begin
    if (rst) begin
      fAddrQ <= '0;
      dAddrQ <= '0;
      wDataQ <= '0;
      portQ  <= '0;
      wideQ  <= 1'b0;
    end else begin
      if (strobes.latchHalf) begin
        fAddrQ <= fetchAddr;
      end
      if (strobes.latchCycle) begin
        dAddrQ <= dataAddr;
        wDataQ <= wrData;
        portQ  <= portReg;
        wideQ  <= dataWide;
      end
    end
  end

  assign hiAddr = strobes.dataCycle ? dAddrQ[ADDR_W-1:DATA_W] : fAddrQ[ADDR_W-1:DATA_W];

  // per-bit clearing of address bits at or above the kept range
  for (genvar gi = 0; gi < HI_W; gi++) begin : g_limit
    if (gi + DATA_W >= KEEP_BITS) begin : g_clr
      assign hiLimited[gi] = hiAddr[gi] & ~limitTo4k;
    end else begin : g_keep
      assign hiLimited[gi] = hiAddr[gi];
    end
  end

  always_comb begin
    if (strobes.dataCycle && !wideQ) busHi = portQ;
    else                             busHi = hiLimited;
  end

  always_comb begin
    if (strobes.driveWdata)     busLoOut = wDataQ;
    else if (strobes.dataCycle) busLoOut = dAddrQ[DATA_W-1:0];
    else                        busLoOut = fAddrQ[DATA_W-1:0];
  end

  assign busLoOe = strobes.driveAddr | strobes.driveWdata;

endmodule

// File: rtl/extbus_sequencer.sv
module extbus_sequencer
  import extbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int KEEP_BITS = 12
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetchEn,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic                     dataReq,
  input  logic                     dataWrite,
  input  logic                     dataWide,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] portReg,
  input  logic                     limitTo4k,
  output logic                     ale,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        busLoOut,
  output logic                     busLoOe,
  output logic [ADDR_W-DATA_W-1:0] busHi
);

  logic [PH_W-1:0] phase;
  logic            halfEnd;
  logic            cycleEnd;
  busStrobes_t     strobes;

  extbus_timebase u_timebase (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .halfEnd  (halfEnd),
    .cycleEnd (cycleEnd)
  );

  extbus_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .halfEnd   (halfEnd),
    .cycleEnd  (cycleEnd),
    .fetchEn   (fetchEn),
    .dataReq   (dataReq),
    .dataWrite (dataWrite),
    .strobes   (strobes)
  );

  extbus_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEEP_BITS (KEEP_BITS)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .fetchAddr (fetchAddr),
    .dataAddr  (dataAddr),
    .dataWide  (dataWide),
    .wrData    (wrData),
    .portReg   (portReg),
    .limitTo4k (limitTo4k),
    .busLoOut  (busLoOut),
    .busLoOe   (busLoOe),
    .busHi     (busHi)
  );

  assign ale   = strobes.ale;
  assign psenN = strobes.psenN;
  assign rdN   = strobes.rdN;
  assign wrN   = strobes.wrN;

endmodule

// File: rtl/extbus_sequencer_chk.sv
module extbus_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psenN,
  input logic rdN,
  input logic wrN,
  input logic busLoOe
);

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  a_r11_data_strobe_alone: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> (psenN && !ale));

  a_r11_psen_not_with_ale: assert property (@(posedge clk) disable iff (rst)
    !psenN |-> !ale);

  a_r4_bus_released_under_psen: assert property (@(posedge clk) disable iff (rst)
    !psenN |-> !busLoOe);

  a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);

  a_r2_ale_not_three: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale);

  a_r7_write_byte_driven: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> busLoOe);

  a_r6_ale_after_strobe: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdN) || $rose(wrN)) |=> $rose(ale));

endmodule

bind extbus_sequencer extbus_sequencer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ale     (ale),
  .psenN   (psenN),
  .rdN     (rdN),
  .wrN     (wrN),
  .busLoOe (busLoOe)
);

// File: tb/extbus_sequencer_tb_top.sv
`timescale 1ns/1ps
module extbus_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetchEn = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        dataReq = 1'b0;
  logic        dataWrite = 1'b0;
  logic        dataWide = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  portReg = '0;
  logic        limitTo4k = 1'b0;
  logic        ale, psenN, rdN, wrN, busLoOe;
  logic [7:0]  busLoOut, busHi;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  extbus_sequencer dut_i (
    .clk(clk), .rst(rst), .fetchEn(fetchEn), .fetchAddr(fetchAddr),
    .dataReq(dataReq), .dataWrite(dataWrite), .dataWide(dataWide),
    .dataAddr(dataAddr), .wrData(wrData), .portReg(portReg),
    .limitTo4k(limitTo4k), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .busLoOut(busLoOut), .busLoOe(busLoOe), .busHi(busHi)
  );

  task automatic chk(input string tag, input string what, input int q,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s phase=%0d actual=%h expected=%h", tag, what, q, act, exp);
    end
  endtask

  function automatic logic [7:0] limHi(input logic [7:0] v);
    return limitTo4k ? {4'b0000, v[3:0]} : v;
  endfunction

  // R2 R3 R4 R8 R10: one fetch machine cycle, inputs set while phase 11
  task automatic fetchCycle(input logic fen0, input logic fen1,
                            input logic [15:0] a0, input logic [15:0] a1);
    dataReq = 1'b0; dataWrite = 1'b1; dataWide = 1'b1;
    fetchEn = fen0; fetchAddr = a0;
    for (int q = 0; q < 12; q++) begin
      logic [15:0] a; logic fon; int p; string hiTag;
      @(posedge clk); @(negedge clk);
      a = (q < 6) ? a0 : a1; fon = (q < 6) ? fen0 : fen1; p = q % 6;
      hiTag = limitTo4k ? "R9" : ((q == 2 || q == 8) ? "R10" : "R8");
      chk("R2", "ale", q, {7'b0, ale}, {7'b0, (p < 2)});
      chk("R3", "psenN", q, {7'b0, psenN}, {7'b0, !(fon && p >= 3)});
      chk("R11", "rdN", q, {7'b0, rdN}, 8'd1);
      chk("R11", "wrN", q, {7'b0, wrN}, 8'd1);
      chk("R4", "busLoOe", q, {7'b0, busLoOe}, {7'b0, (p == 1 || p == 2)});
      if (p == 1 || p == 2) chk((q == 2 || q == 8) ? "R10" : "R4", "busLoOut", q, busLoOut, a[7:0]);
      chk(hiTag, "busHi", q, busHi, limHi(a[15:8]));
      if (q == 1) begin fetchAddr = ~a0; fetchEn = ~fen0; end
      if (q == 5) begin fetchAddr = a1; fetchEn = fen1; end
      if (q == 7) begin fetchAddr = ~a1; fetchEn = ~fen1; end
    end
  endtask

  // R5 R6 R7 R8 R9 R10: one data machine cycle
  task automatic dataCycle(input logic wr, input logic wide, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] pr);
    logic [7:0] expHi;
    dataReq = 1'b1; dataWrite = wr; dataWide = wide; dataAddr = a;
    wrData = wd; portReg = pr; fetchEn = 1'b1; fetchAddr = 16'h7777;
    expHi = wide ? limHi(a[15:8]) : pr;
    for (int q = 0; q < 12; q++) begin
      logic stb; logic oe; string hiTag;
      @(posedge clk); @(negedge clk);
      stb = (q >= 5 && q <= 10);
      oe = (q == 1 || q == 2) || (wr && q >= 3);
      hiTag = limitTo4k ? "R9" : (q >= 3 ? "R10" : "R8");
      chk("R5", "ale", q, {7'b0, ale}, {7'b0, (q < 2)});
      chk("R5", "psenN", q, {7'b0, psenN}, 8'd1);
      chk("R6", "rdN", q, {7'b0, rdN}, {7'b0, !(stb && !wr)});
      chk("R6", "wrN", q, {7'b0, wrN}, {7'b0, !(stb && wr)});
      chk("R11", "bothStrobes", q, {7'b0, (!rdN && !wrN)}, 8'd0);
      chk("R7", "busLoOe", q, {7'b0, busLoOe}, {7'b0, oe});
      if (oe) chk(q >= 3 ? "R10" : "R7", "busLoOut", q, busLoOut, (q <= 2) ? a[7:0] : wd);
      chk(hiTag, "busHi", q, busHi, expHi);
      if (q == 2) begin
        dataAddr = ~a; wrData = ~wd; portReg = ~pr;
        dataWrite = ~wr; dataWide = ~wide; dataReq = 1'b0;
      end
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ale", 0, {7'b0, ale}, 8'd0);
    chk("R1", "psenN", 0, {7'b0, psenN}, 8'd1);
    chk("R1", "rdN", 0, {7'b0, rdN}, 8'd1);
    chk("R1", "wrN", 0, {7'b0, wrN}, 8'd1);
    chk("R1", "busLoOe", 0, {7'b0, busLoOe}, 8'd0);
    rst = 1'b0;
    fetchCycle(1'b1, 1'b1, 16'h1234, 16'hABCD);
    fetchCycle(1'b0, 1'b1, 16'h5678, 16'h9A0F);  // R2 R3: ale without fetch
    fetchCycle(1'b1, 1'b0, 16'hC0DE, 16'h4321);
    dataCycle(1'b0, 1'b1, 16'hBEEF, 8'h00, 8'h11);
    fetchCycle(1'b1, 1'b1, 16'h2001, 16'h2002);
    dataCycle(1'b1, 1'b0, 16'h0055, 8'h5A, 8'hC3);
    dataCycle(1'b0, 1'b0, 16'h00A7, 8'h33, 8'h3C);  // back to back
    dataCycle(1'b1, 1'b1, 16'h8421, 8'hE1, 8'h99);
    limitTo4k = 1'b1;
    fetchCycle(1'b1, 1'b1, 16'hF123, 16'h9FED);
    dataCycle(1'b0, 1'b1, 16'hFFEE, 8'h00, 8'h77);
    dataCycle(1'b1, 1'b0, 16'hF00D, 8'hA5, 8'hF0);  // R9: port byte unmasked
    limitTo4k = 1'b0;
    fetchCycle(1'b1, 1'b1, 16'hF123, 16'h0FFF);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule